// File: doc/BRIEF.md
# Stride Pattern Candidate Detector

This block takes a window of three adjacent zone access maps (the zone holding a demand line and the zones on either side of it) and finds lines worth prefetching. Each line in the window carries a 2-bit state. When a demand request is presented, a shifter moves the window so the demand line sits at a fixed position. A bank of per-stride detectors then tests every stride in the same cycle. A forward candidate at distance k is raised when the two lines at distances k and 2k behind the demand were both accessed. A backward candidate at distance k is raised when the two lines at distances k and 2k ahead of it were both accessed. In both cases the target line must still be untouched.

The access order of the history plays no part in detection. Only the set of marked lines matters, so requests that were reordered or duplicated upstream give the same result. The results are registered. They go to a later selection stage that picks the nearest candidates and forms addresses.

Top module: `stride_cand_detect`

## Requirements
- R1: While `rst_n` is low, `cand_valid`, `fwd_cand` and `bwd_cand` are all zero.
- R2: A request sampled with `dmd_valid` high at a rising edge gives `cand_valid` high for the cycle after that edge. The candidate vectors for that request appear in that same cycle. `cand_valid` is low after every edge where `dmd_valid` was low.
- R3: When `dmd_valid` is low at an edge, `fwd_cand` and `bwd_cand` keep their values, whatever the other inputs do.
- R4: Line i of the window sits at `win_state[2i+1:2i]`. Line 0 is the lowest line of the lower zone. The demand line is p = ZONE + `dmd_off`. Bit k-1 of `fwd_cand` (k = 1..ZONE) is set exactly when line p+k is eligible and lines p-k and p-2k are both accessed.
- R5: Bit k-1 of `bwd_cand` is set exactly when line p-k is eligible and lines p+k and p+2k are both accessed.
- R6: The states are encoded as 00 untouched, 01 prefetched, 10 accessed and 11 hit-on-prefetch. Only a line in state 00 is eligible as a candidate.
- R7: States 10 and 11 always count as accessed. State 01 counts as accessed only while `pf_as_acc` is 1. State 00 never counts.
- R8: A line whose index falls outside 0..3·ZONE-1 counts as not accessed. Strides whose p-2k or p+2k leaves the window therefore raise nothing.
- R9: All strides are evaluated at once, so several bits may be set together. For example, with lines at zone offsets 1, 3 and 4 accessed and a demand at offset 5, `fwd_cand` equals 0x3 (offsets 6 and 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmd_valid | input | 1 | A demand request is present this cycle |
| dmd_off | input | $clog2(ZONE) | Line offset of the demand within the centre zone |
| pf_as_acc | input | 1 | Count prefetched lines as accessed |
| win_state | input | 6·ZONE | 2-bit states of the three-zone window |
| cand_valid | output | 1 | Candidate vectors belong to the previous request |
| fwd_cand | output | ZONE | Forward candidates, bit k-1 for line p+k |
| bwd_cand | output | ZONE | Backward candidates, bit k-1 for line p-k |

## Verification
There is one register between inputs and outputs. A request driven on a falling edge is captured at the next rising edge. Its valid flag and both candidate vectors are sampled at the following falling edge. One cycle later, at the next falling edge, the bench checks that `cand_valid` has dropped. By then it has scrambled the window, offset and flag without a request, so that check also shows the vectors held. Expected vectors come from a bench function that applies the stride rule line by line over the window. Directed cases at both ends of the centre zone exercise the window bounds.

// File: rtl/stride_cand_detect.sv
module stride_cand_detect #(
  parameter int ZONE = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dmd_valid,
  input  logic [$clog2(ZONE)-1:0] dmd_off,
  input  logic                    pf_as_acc,
  input  logic [6*ZONE-1:0]       win_state,
  output logic                    cand_valid,
  output logic [ZONE-1:0]         fwd_cand,
  output logic [ZONE-1:0]         bwd_cand
);
  localparam int WIN = 3*ZONE;
  localparam int EXT = 7*ZONE;
  localparam int SW  = $clog2(EXT);
  localparam int IW  = 2*ZONE + 1;

  logic [WIN-1:0]  acc_v, idle_v;
  logic [EXT-1:0]  acc_al;
  logic [IW-1:0]   idle_al;
  logic [SW-1:0]   shamt;
  logic [ZONE-1:0] fwd_d, bwd_d;
  logic            unused_acc_bits;

  for (genvar i = 0; i < WIN; i++) begin : g_state
    assign idle_v[i] = (win_state[2*i +: 2] == 2'b00);
    assign acc_v[i]  = win_state[2*i+1] | (pf_as_acc & win_state[2*i]);
  end

  // acc_al[2*ZONE + d] holds line p+d; zero padding stands for lines outside the window
  assign shamt   = SW'(ZONE) + SW'(dmd_off);
  assign acc_al  = {{(2*ZONE){1'b0}}, acc_v, {(2*ZONE){1'b0}}} >> shamt;
  // idle_al[ZONE + d] holds line p+d for |d| <= ZONE
  assign idle_al = IW'(idle_v >> dmd_off);
  assign unused_acc_bits = ^acc_al;

  for (genvar k = 1; k <= ZONE; k++) begin : g_stride
    assign fwd_d[k-1] = idle_al[ZONE+k] & acc_al[2*ZONE-k] & acc_al[2*ZONE-2*k];
    assign bwd_d[k-1] = idle_al[ZONE-k] & acc_al[2*ZONE+k] & acc_al[2*ZONE+2*k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_valid <= 1'b0;
      fwd_cand   <= '0;
      bwd_cand   <= '0;
    end else begin
      cand_valid <= dmd_valid;
      if (dmd_valid) begin
        fwd_cand <= fwd_d;
        bwd_cand <= bwd_d;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dmd_valid |=> cand_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dmd_valid |=> !cand_valid);
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dmd_valid |=> ($stable(fwd_cand) && $stable(bwd_cand)));
  assert_fwd_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && fwd_cand[0]) |-> ($past(win_state[2*(ZONE+1+dmd_off) +: 2]) == 2'b00));
  assert_bwd_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && bwd_cand[0]) |-> ($past(win_state[2*(ZONE-1+dmd_off) +: 2]) == 2'b00));
  assert_unit_stride_dirs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> !(fwd_cand[0] && bwd_cand[0]));
endmodule

// File: tb/sim_stride_cand_detect.sv
module sim_stride_cand_detect;
  localparam int Z = 64;
  localparam int W = 3*Z;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           dmd_valid = 1'b0;
  logic [5:0]     dmd_off = '0;
  logic           pf_as_acc = 1'b0;
  logic [2*W-1:0] win_state = '0;
  logic           cand_valid;
  logic [Z-1:0]   fwd_cand, bwd_cand;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  stride_cand_detect #(.ZONE(Z)) u0 (
    .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_off(dmd_off),
    .pf_as_acc(pf_as_acc), .win_state(win_state), .cand_valid(cand_valid),
    .fwd_cand(fwd_cand), .bwd_cand(bwd_cand));

  function automatic logic acc_at(logic [2*W-1:0] w, int i, logic pf);
    logic [1:0] s;
    if (i < 0 || i >= W) return 1'b0;
    s = w[2*i +: 2];
    return s[1] | (pf & s[0]);
  endfunction

  function automatic logic idle_at(logic [2*W-1:0] w, int i);
    if (i < 0 || i >= W) return 1'b0;
    return w[2*i +: 2] == 2'b00;
  endfunction

  function automatic logic [Z-1:0] exp_fwd(logic [2*W-1:0] w, int off, logic pf);
    logic [Z-1:0] r = '0;
    int p = Z + off;
    for (int k = 1; k <= Z; k++)
      r[k-1] = idle_at(w, p+k) & acc_at(w, p-k, pf) & acc_at(w, p-2*k, pf);
    return r;
  endfunction

  function automatic logic [Z-1:0] exp_bwd(logic [2*W-1:0] w, int off, logic pf);
    logic [Z-1:0] r = '0;
    int p = Z + off;
    for (int k = 1; k <= Z; k++)
      r[k-1] = idle_at(w, p-k) & acc_at(w, p+k, pf) & acc_at(w, p+2*k, pf);
    return r;
  endfunction

  task automatic chk(string req, logic [Z-1:0] act, logic [Z-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_line(inout logic [2*W-1:0] w, input int i, input logic [1:0] s);
    w[2*i +: 2] = s;
  endtask

  task automatic run(logic [2*W-1:0] w, int off, logic pf, string req,
                     logic use_const, logic [Z-1:0] cf, logic [Z-1:0] cb);
    logic [Z-1:0] ef, eb, hf, hb;
    ef = exp_fwd(w, off, pf);
    eb = exp_bwd(w, off, pf);
    @(negedge clk);
    win_state = w; dmd_off = 6'(off); pf_as_acc = pf; dmd_valid = 1'b1;
    @(negedge clk);
    dmd_valid = 1'b0;
    chk({req, " R2 valid"}, Z'(cand_valid), Z'(1));
    chk({req, " R4 fwd"}, fwd_cand, ef);
    chk({req, " R5 bwd"}, bwd_cand, eb);
    if (use_const) begin
      chk({req, " fwd const"}, fwd_cand, cf);
      chk({req, " bwd const"}, bwd_cand, cb);
    end
    hf = fwd_cand; hb = bwd_cand;
    win_state = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                 $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    dmd_off = 6'($urandom); pf_as_acc = ~pf;
    @(negedge clk);
    chk({req, " R2 valid low"}, Z'(cand_valid), Z'(0));
    chk({req, " R3 hold fwd"}, fwd_cand, hf);
    chk({req, " R3 hold bwd"}, bwd_cand, hb);
  endtask

  function automatic logic [2*W-1:0] rand_win(int dens);
    logic [2*W-1:0] w = '0;
    for (int i = 0; i < W; i++)
      if (($urandom % 16) < dens) w[2*i +: 2] = 2'($urandom % 3 + 1);
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2*W-1:0] w;
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    chk("R1 reset valid", Z'(cand_valid), Z'(0));
    chk("R1 reset fwd", fwd_cand, '0);
    chk("R1 reset bwd", bwd_cand, '0);
    rst_n = 1'b1;

    // R9: offsets 1,3,4 accessed, demand at 5
    w = '0;
    set_line(w, Z+1, 2'b10); set_line(w, Z+3, 2'b10); set_line(w, Z+4, 2'b10);
    run(w, 5, 1'b0, "R9 example", 1'b1, 64'h3, 64'h0);

    // R6: line at offset 6 already prefetched, so only stride 2 stays
    set_line(w, Z+6, 2'b01);
    run(w, 5, 1'b0, "R6 non-idle target", 1'b1, 64'h2, 64'h0);

    // R5: backward, demand at 20, offsets 21,22,24 accessed (11 state mixed in)
    w = '0;
    set_line(w, Z+21, 2'b10); set_line(w, Z+22, 2'b11); set_line(w, Z+24, 2'b10);
    run(w, 20, 1'b0, "R5 backward", 1'b1, 64'h0, 64'h3);

    // R7: prefetched history lines count only with pf_as_acc
    w = '0;
    set_line(w, Z+3, 2'b01); set_line(w, Z+4, 2'b01);
    run(w, 5, 1'b0, "R7 pf ignored", 1'b1, 64'h0, 64'h0);
    run(w, 5, 1'b1, "R7 pf counted", 1'b1, 64'h1, 64'h0);

    // R8: demand at low edge, lower zone fully accessed
    w = '0;
    for (int i = 0; i < Z; i++) set_line(w, i, 2'b10);
    run(w, 0, 1'b0, "R8 low edge", 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0);

    // R8: demand at high edge, upper zone fully accessed
    w = '0;
    for (int i = 2*Z; i < W; i++) set_line(w, i, 2'b11);
    run(w, Z-1, 1'b0, "R8 high edge", 1'b1, 64'h0, 64'h0000_0000_FFFF_FFFF);

    // R4 R5 R9: random windows at several densities
    for (int n = 0; n < 60; n++)
      run(rand_win(2 + (n % 10)), int'($urandom % Z), 1'($urandom), "rand", 1'b0, '0, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule